// File: doc/BRIEF.md
# Reset Boot Address Selector

After every reset this block decides where an 8-bit microcontroller core fetches its first instruction. It holds the core in reset, reads two nonvolatile configuration bytes over a request/valid handshake, and combines them with a hardware "force boot loader" request that is sampled once as reset ends. The configuration bytes are a boot status byte and an 8-bit boot page.

When the status byte is zero and no force request was seen, the core starts at address zero. In every other case the boot page is placed in the upper byte of the start address and the lower byte is zero. A factory page of 8'h1E gives 16'h1E00 on the 8 KB build, and 8'h0E gives 16'h0E00 on the 4 KB build. The block then releases the core, pulses a one-cycle valid, and holds the address until the next reset. A build parameter sets the code space size. A page that lies beyond that size is still used, but a range flag is raised.

Top module: `boot_start_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `core_reset_n`=0, `start_addr_valid`=0, `cfg_rd_req`=0, `vector_out_of_range`=0 and `start_addr`=16'h0000.
- R2: After reset the block requests the status byte (`cfg_rd_sel`=0) first and then the boot page (`cfg_rd_sel`=1). Each request holds `cfg_rd_req` high with `cfg_rd_sel` stable until the cycle `cfg_rd_valid` is seen. `cfg_rd_req` is low for one cycle between the two reads, and no request is made after the page read.
- R3: With status byte 8'h00 and no latched force request, `start_addr` is 16'h0000.
- R4: With any nonzero status byte, `start_addr` is {page, 8'h00}; for example page 8'h1E gives 16'h1E00.
- R5: A latched force request gives the same result as a nonzero status byte, even when the status byte is zero.
- R6: `force_isp` passes through two synchronizing flops and is latched only in the first clock cycle after `rst` falls. Changes after that cycle have no effect until the next reset.
- R7: `start_addr_valid` is high for exactly one cycle, in the cycle after the page read's valid is accepted. `core_reset_n` rises in that same cycle.
- R8: Once `core_reset_n` is high, `start_addr`, `vector_out_of_range` and `core_reset_n` do not change until the next reset.
- R9: `cfg_rd_valid` pulses while `cfg_rd_req` is low are ignored, and their data has no effect on the result.
- R10: `vector_out_of_range` is 1 only when the page is used and page*256 ≥ CODE_KB*1024 (page ≥ 8'h20 when CODE_KB=8, page ≥ 8'h10 when CODE_KB=4). The address still uses that page. When the zero address is chosen, the flag is 0.
- R11: The decision is made again after every reset, with fresh reads and a fresh force sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_isp | input | 1 | Asynchronous hardware request to start in the boot loader |
| cfg_rd_req | output | 1 | Configuration read request, held until valid |
| cfg_rd_sel | output | 1 | Item select: 0 = status byte, 1 = boot page |
| cfg_rd_valid | input | 1 | Read data valid |
| cfg_rd_data | input | 8 | Read data |
| core_reset_n | output | 1 | Low holds the core in reset |
| start_addr | output | 16 | First fetch address |
| start_addr_valid | output | 1 | One-cycle pulse marking the decision |
| vector_out_of_range | output | 1 | Chosen page lies beyond the code space |

## Verification
The properties assume that the configuration store answers each request with exactly one valid pulse and does not withdraw it. They also assume that `force_isp` is held steady for at least two cycles before reset ends, so the synchronizer output is settled when it is sampled. The bench's responder waits a chosen number of cycles (zero up to many) after each new request before it answers. It changes the force input only well before reset ends, or after the sampling cycle. It adds unsolicited valid pulses with data 8'hFF only while no request is outstanding.

// File: rtl/boot_pkg.sv
package boot_pkg;

  // Sequencing phases of the configuration fetch.
  typedef enum logic [2:0] {
    PH_LATCH = 3'd0,  // first cycle after reset: sample force request
    PH_STAT  = 3'd1,  // status byte request outstanding
    PH_GAP   = 3'd2,  // one idle cycle between the two reads
    PH_VEC   = 3'd3,  // boot page request outstanding
    PH_RUN   = 3'd4   // decision made, core running
  } boot_phase_t;

  // Number of 256-byte pages in a code space of the given size in KB.
  function automatic int unsigned pages_in(input int unsigned code_kb);
    return (code_kb * 1024) / 256;
  endfunction

endpackage

// File: rtl/boot_sync.sv
module boot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  // Free-running chain so a request held through reset reaches the output.
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/boot_cfg_fetch.sv
module boot_cfg_fetch
  import boot_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_sync,
  output logic              rd_req,
  output logic              rd_sel,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              fetch_done,
  output logic              boot_sel,
  output logic [BYTE_W-1:0] page
);

  boot_phase_t phase;
  logic        force_lat;
  logic        stat_nz;
  logic        accept;

  // A valid only counts while our own request is outstanding.
  assign accept = rd_valid && rd_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_LATCH;
      rd_req    <= 1'b0;
      rd_sel    <= 1'b0;
      force_lat <= 1'b0;
      stat_nz   <= 1'b0;
    end else begin
      case (phase)
        PH_LATCH: begin
          force_lat <= force_sync;
          rd_req    <= 1'b1;
          rd_sel    <= 1'b0;
          phase     <= PH_STAT;
        end
        PH_STAT: begin
          if (accept) begin
            stat_nz <= |rd_data;
            rd_req  <= 1'b0;
            phase   <= PH_GAP;
          end
        end
        PH_GAP: begin
          rd_req <= 1'b1;
          rd_sel <= 1'b1;
          phase  <= PH_VEC;
        end
        PH_VEC: begin
          if (accept) begin
            rd_req <= 1'b0;
            phase  <= PH_RUN;
          end
        end
        default: begin
          rd_req <= 1'b0;
          phase  <= PH_RUN;
        end
      endcase
    end
  end

  assign fetch_done = (phase == PH_VEC) && accept;
  assign boot_sel   = stat_nz || force_lat;
  assign page       = rd_data;

endmodule

// File: rtl/boot_addr_calc.sv
module boot_addr_calc
  import boot_pkg::*;
#(
  parameter int CODE_KB = 8,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_done,
  input  logic              boot_sel,
  input  logic [BYTE_W-1:0] page,
  output logic [ADDR_W-1:0] start_addr,
  output logic              start_addr_valid,
  output logic              core_reset_n,
  output logic              out_of_range
);

  localparam int LOW_W = ADDR_W - BYTE_W;
  localparam logic [BYTE_W:0] PAGE_LIMIT = (BYTE_W+1)'(pages_in(CODE_KB));

  logic beyond;
  assign beyond = ({1'b0, page} >= PAGE_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr       <= '0;
      start_addr_valid <= 1'b0;
      core_reset_n     <= 1'b0;
      out_of_range     <= 1'b0;
    end else begin
      start_addr_valid <= 1'b0;
      if (fetch_done) begin
        start_addr       <= boot_sel ? {page, {LOW_W{1'b0}}} : '0;
        out_of_range     <= boot_sel && beyond;
        start_addr_valid <= 1'b1;
        core_reset_n     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/boot_start_sel.sv
module boot_start_sel #(
  parameter int CODE_KB     = 8,
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_isp,
  output logic              cfg_rd_req,
  output logic              cfg_rd_sel,
  input  logic              cfg_rd_valid,
  input  logic [BYTE_W-1:0] cfg_rd_data,
  output logic              core_reset_n,
  output logic [ADDR_W-1:0] start_addr,
  output logic              start_addr_valid,
  output logic              vector_out_of_range
);

  logic              force_sync;
  logic              fetch_done;
  logic              boot_sel;
  logic [BYTE_W-1:0] page;

  boot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (force_isp),
    .q   (force_sync)
  );

  boot_cfg_fetch #(.BYTE_W(BYTE_W)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .force_sync (force_sync),
    .rd_req     (cfg_rd_req),
    .rd_sel     (cfg_rd_sel),
    .rd_valid   (cfg_rd_valid),
    .rd_data    (cfg_rd_data),
    .fetch_done (fetch_done),
    .boot_sel   (boot_sel),
    .page       (page)
  );

  boot_addr_calc #(
    .CODE_KB (CODE_KB),
    .BYTE_W  (BYTE_W),
    .ADDR_W  (ADDR_W)
  ) u_calc (
    .clk              (clk),
    .rst              (rst),
    .fetch_done       (fetch_done),
    .boot_sel         (boot_sel),
    .page             (page),
    .start_addr       (start_addr),
    .start_addr_valid (start_addr_valid),
    .core_reset_n     (core_reset_n),
    .out_of_range     (vector_out_of_range)
  );

endmodule

// File: rtl/boot_start_sel_chk.sv
module boot_start_sel_chk #(
  parameter int CODE_KB = 8,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rd_req,
  input logic              cfg_rd_sel,
  input logic              cfg_rd_valid,
  input logic              core_reset_n,
  input logic [ADDR_W-1:0] start_addr,
  input logic              start_addr_valid,
  input logic              vector_out_of_range
);

  localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'((CODE_KB * 1024) / 256);

  p_reset_hold_r1: assert property (@(posedge clk)
    rst |=> (!core_reset_n && !start_addr_valid && !cfg_rd_req && !vector_out_of_range));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_req && !cfg_rd_valid) |=> (cfg_rd_req && $stable(cfg_rd_sel)));

  p_no_req_running_r2: assert property (@(posedge clk) disable iff (rst)
    core_reset_n |-> !cfg_rd_req);

  p_low_byte_zero_r4: assert property (@(posedge clk) disable iff (rst)
    start_addr_valid |-> (start_addr[ADDR_W-BYTE_W-1:0] == '0));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    start_addr_valid |=> !start_addr_valid);

  p_release_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_reset_n) |-> start_addr_valid);

  p_hold_after_release_r8: assert property (@(posedge clk) disable iff (rst)
    core_reset_n |=> (core_reset_n && $stable(start_addr) && $stable(vector_out_of_range)));

  p_range_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (start_addr_valid && vector_out_of_range) |->
      ({1'b0, start_addr[ADDR_W-1:ADDR_W-BYTE_W]} >= LIMIT));

endmodule

bind boot_start_sel boot_start_sel_chk #(
  .CODE_KB (CODE_KB),
  .BYTE_W  (BYTE_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk                 (clk),
  .rst                 (rst),
  .cfg_rd_req          (cfg_rd_req),
  .cfg_rd_sel          (cfg_rd_sel),
  .cfg_rd_valid        (cfg_rd_valid),
  .core_reset_n        (core_reset_n),
  .start_addr          (start_addr),
  .start_addr_valid    (start_addr_valid),
  .vector_out_of_range (vector_out_of_range)
);

// File: tb/test_boot_start_sel.sv
`timescale 1ns/1ps
module test_boot_start_sel;

  localparam int CODE_KB = 8;
  localparam int LIM     = (CODE_KB * 1024) / 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        force_isp = 1'b0;
  logic        cfg_rd_req;
  logic        cfg_rd_sel;
  logic        cfg_rd_valid = 1'b0;
  logic [7:0]  cfg_rd_data = 8'h00;
  logic        core_reset_n;
  logic [15:0] start_addr;
  logic        start_addr_valid;
  logic        vector_out_of_range;

  always #2 clk = ~clk;

  boot_start_sel #(.CODE_KB(CODE_KB)) i_boot_start_sel (
    .clk                 (clk),
    .rst                 (rst),
    .force_isp           (force_isp),
    .cfg_rd_req          (cfg_rd_req),
    .cfg_rd_sel          (cfg_rd_sel),
    .cfg_rd_valid        (cfg_rd_valid),
    .cfg_rd_data         (cfg_rd_data),
    .core_reset_n        (core_reset_n),
    .start_addr          (start_addr),
    .start_addr_valid    (start_addr_valid),
    .vector_out_of_range (vector_out_of_range)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Configuration store: answers after mem_lat cycles, optional junk pulses.
  logic [7:0] mem_stat = 8'h00;
  logic [7:0] mem_vec  = 8'h00;
  int         mem_lat  = 0;
  bit         spur_en  = 1'b0;
  int         wait_cnt = 0;
  bit         was_req  = 1'b0;

  always @(negedge clk) begin
    if (cfg_rd_req) begin
      if (!was_req) wait_cnt = 0;
      if (wait_cnt >= mem_lat) begin
        cfg_rd_valid <= 1'b1;
        cfg_rd_data  <= cfg_rd_sel ? mem_vec : mem_stat;
        wait_cnt = 0;
      end else begin
        cfg_rd_valid <= 1'b0;
        wait_cnt++;
      end
    end else if (spur_en && !cfg_rd_valid) begin
      cfg_rd_valid <= 1'b1;
      cfg_rd_data  <= 8'hFF;
    end else begin
      cfg_rd_valid <= 1'b0;
    end
    was_req = cfg_rd_req;
  end

  // Behavioural reference, advanced at each rising edge.
  int         m_step = 0;
  bit         m_s1 = 0, m_s2 = 0, m_force = 0, m_nz = 0;
  bit         m_req = 0, m_sel = 0, m_run = 0, m_av = 0, m_oor = 0;
  int         m_addr = 0;
  bit         m_live = 0;

  always @(posedge clk) begin
    bit in_v;
    logic [7:0] in_d;
    in_v = cfg_rd_valid;
    in_d = cfg_rd_data;
    m_av = 0;
    if (rst) begin
      m_step = 0; m_req = 0; m_sel = 0; m_run = 0; m_addr = 0; m_oor = 0;
      m_force = 0; m_nz = 0;
    end else if (m_step == 0) begin
      m_force = m_s2; m_req = 1; m_sel = 0; m_step = 1;
    end else if (m_step == 1) begin
      if (in_v) begin m_nz = (in_d != 0); m_req = 0; m_step = 2; end
    end else if (m_step == 2) begin
      m_req = 1; m_sel = 1; m_step = 3;
    end else if (m_step == 3) begin
      if (in_v) begin
        m_req = 0; m_step = 4; m_av = 1; m_run = 1;
        if (m_nz || m_force) begin
          m_addr = int'(in_d) * 256;
          m_oor  = (int'(in_d) >= LIM);
        end else begin
          m_addr = 0;
          m_oor  = 0;
        end
      end
    end
    m_s2 = m_s1;
    m_s1 = force_isp;
    m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      chk(cfg_rd_req === m_req, "R2", "req vs model", cfg_rd_req, m_req);
      if (m_req) chk(cfg_rd_sel === m_sel, "R2", "sel vs model", cfg_rd_sel, m_sel);
      chk(core_reset_n === m_run, "R1", "core_reset_n vs model", core_reset_n, m_run);
      chk(start_addr_valid === m_av, "R7", "valid vs model", start_addr_valid, m_av);
      chk(start_addr === 16'(m_addr), "R4", "addr vs model", start_addr, m_addr);
      chk(vector_out_of_range === m_oor, "R10", "range vs model", vector_out_of_range, m_oor);
    end
  end

  // One boot decision with directed checks on the outcome (each is R11).
  task automatic boot_run(input logic [7:0] st, input logic [7:0] pg,
                          input bit frc, input bit frc_after, input int lat,
                          input bit spur, input int exp_addr, input bit exp_oor,
                          input string tag);
    int pulses;
    bit seen;
    @(negedge clk);
    rst = 1'b1; mem_stat = st; mem_vec = pg; mem_lat = lat;
    spur_en = spur; force_isp = frc;
    repeat (4) @(negedge clk);
    chk(core_reset_n === 1'b0 && start_addr_valid === 1'b0 && cfg_rd_req === 1'b0
        && start_addr === 16'h0 && vector_out_of_range === 1'b0,
        "R1", "outputs in reset", {core_reset_n, start_addr_valid, cfg_rd_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    force_isp = frc_after;
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (start_addr_valid === 1'b1) seen = 1;
      else @(negedge clk);
    end
    chk(seen, tag, "valid pulse seen", seen, 1);
    chk(start_addr === 16'(exp_addr), tag, "start address", start_addr, exp_addr);
    chk(vector_out_of_range === exp_oor, "R10", "range flag", vector_out_of_range, exp_oor);
    chk(core_reset_n === 1'b1, "R7", "release with valid", core_reset_n, 1);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (start_addr_valid) pulses++;
      chk(start_addr === 16'(exp_addr) && core_reset_n === 1'b1, "R8",
          "held after release", start_addr, exp_addr);
      chk(cfg_rd_req === 1'b0, "R2", "no request after page read", cfg_rd_req, 0);
    end
    chk(pulses == 0, "R7", "single valid pulse", pulses, 0);
    spur_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    boot_run(8'h00, 8'h1E, 0, 0, 2, 0, 16'h0000, 0, "R3");
    boot_run(8'h01, 8'h1E, 0, 0, 1, 0, 16'h1E00, 0, "R4");
    boot_run(8'h5A, 8'h0E, 0, 0, 0, 0, 16'h0E00, 0, "R4");
    boot_run(8'h00, 8'h0E, 1, 1, 3, 0, 16'h0E00, 0, "R5");
    boot_run(8'h00, 8'h33, 0, 1, 2, 0, 16'h0000, 0, "R6");
    boot_run(8'h00, 8'h33, 1, 0, 2, 0, 16'h3300, 1, "R6");
    boot_run(8'h80, 8'h40, 0, 0, 4, 0, 16'h4000, 1, "R10");
    boot_run(8'h02, 8'h20, 0, 0, 0, 0, 16'h2000, 1, "R10");
    boot_run(8'h02, 8'h1F, 0, 0, 0, 0, 16'h1F00, 0, "R10");
    boot_run(8'h00, 8'h40, 0, 0, 1, 0, 16'h0000, 0, "R10");
    boot_run(8'h01, 8'h12, 0, 0, 3, 1, 16'h1200, 0, "R9");
    boot_run(8'h00, 8'h12, 0, 0, 3, 1, 16'h0000, 0, "R9");
    boot_run(8'h03, 8'h07, 0, 0, 20, 0, 16'h0700, 0, "R2");
    boot_run(8'h00, 8'h1E, 0, 0, 0, 0, 16'h0000, 0, "R11");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule